// File: doc/BRIEF.md
# Selectable-Time Input Debounce Filter

This block cleans up eight digital field inputs before they are captured by a parallel-in shift register. Each channel holds a filtered level. That level moves to a new value, high or low, only after the raw input has stayed at that value without a break for a chosen interval. Short glitches and contact bounce therefore never reach the register.

A 2-bit select input picks the interval. The choices are a long hold, a short hold, a straight-through bypass, and a reserved code that acts like the long hold. Time is counted in milliseconds. A shared prescaler divides the system clock, whose frequency is a parameter, into a one-millisecond tick. Each channel keeps its own counter of ticks, so no channel affects another. The raw inputs are taken to be synchronous to the system clock.

Top module: `debounce_bank`

## Requirements
- R1: While `rst` is high at a rising clock edge, every bit of `filt_out` becomes 0 and every channel's count is cleared.
- R2: One millisecond tick occurs every CLK_HZ/1000 system clocks. The first tick falls on the (CLK_HZ/1000)-th rising edge after reset is released.
- R3: With `dbsel` = 2'b11 (long hold, LONG_MS = 3 ms), a channel takes a new raw level on the (LONG_MS+1)-th tick seen while that level differs from its output. After a change, the output holds its old value for at least 3·T edges and takes the new value within 4·T edges, where T = CLK_HZ/1000.
- R4: With `dbsel` = 2'b10 (short hold, SHORT_MS = 1 ms), the same rule applies with SHORT_MS. The output holds for at least T edges and changes within 2·T edges.
- R5: With `dbsel` = 2'b01 (bypass), each `filt_out` bit equals the `raw_in` bit sampled at the previous rising edge, and all counts are held at zero.
- R6: `dbsel` = 2'b00 (reserved) gives exactly the same timing as 2'b11.
- R7: If the raw input goes back to the filtered level before acceptance, that channel's count is cleared. A later difference then has to last the full interval again.
- R8: The rule is the same for rising and falling changes. A low level is accepted after the same interval as a high level.
- R9: Channels filter independently. A change or glitch on one bit never changes the output or the timing of another bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dbsel | input | 2 | Debounce interval select (11 long, 10 short, 01 bypass, 00 reserved = long) |
| raw_in | input | CHANNELS | Raw field inputs, synchronous to `clk` |
| filt_out | output | CHANNELS | Debounced levels for the shift register's parallel inputs |

## Verification
Two events can land in the same cycle. One is a millisecond tick; the other is the raw input returning to the filtered level, or a change of the select code, while a count is running. The bench provokes the first case by cutting a pending change short at arbitrary phases of the prescaler. It provokes the second by switching `dbsel` mid-count during a long randomized stretch of sparse input toggles. A behavioural model counts ticks seen since each channel started to differ and is compared against `filt_out` on every clock. Directed windows also confirm that each transition falls between the earliest and latest edge allowed by the requirements.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

    // Width of the per-channel millisecond counter and of the hold limit
    localparam int MS_W = 8;

    typedef enum logic [1:0] {
        SEL_RESERVED = 2'b00,
        SEL_BYPASS   = 2'b01,
        SEL_SHORT    = 2'b10,
        SEL_LONG     = 2'b11
    } dbsel_e;

    // Filter configuration shared by all channels
    typedef struct packed {
        logic            bypass;
        logic [MS_W-1:0] limit;
    } filt_cfg_t;

    // Hold time in milliseconds for a select code; reserved maps to long
    function automatic logic [MS_W-1:0] hold_ms(input dbsel_e sel,
                                                input int long_ms,
                                                input int short_ms);
        logic [MS_W-1:0] r;
        case (sel)
            SEL_SHORT:  r = MS_W'(short_ms);
            SEL_BYPASS: r = '0;
            default:    r = MS_W'(long_ms);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dbf_tick_gen.sv
module dbf_tick_gen #(
    parameter int CLK_HZ = 125_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int TICKS = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
    localparam int CW    = (TICKS > 1) ? $clog2(TICKS) : 1;

    generate
        if (TICKS == 1) begin : g_every
            assign tick = !rst;
        end else begin : g_div
            logic [CW-1:0] pcnt;

            always_ff @(posedge clk) begin
                if (rst) begin
                    pcnt <= '0;
                end else if (pcnt == CW'(TICKS - 1)) begin
                    pcnt <= '0;
                end else begin
                    pcnt <= pcnt + CW'(1);
                end
            end

            assign tick = (pcnt == CW'(TICKS - 1));

            // Two ticks never fall on neighbouring edges
            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick); // R2
        end
    endgenerate

endmodule

// File: rtl/dbf_mode_decode.sv
module dbf_mode_decode
    import dbf_pkg::*;
#(
    parameter int LONG_MS  = 3,
    parameter int SHORT_MS = 1
) (
    input  logic [1:0] dbsel,
    output filt_cfg_t  cfg
);
    dbsel_e sel;

    always_comb begin
        sel        = dbsel_e'(dbsel);
        cfg.bypass = (sel == SEL_BYPASS);
        cfg.limit  = hold_ms(sel, LONG_MS, SHORT_MS);
    end

endmodule

// File: rtl/dbf_channel.sv
module dbf_channel
    import dbf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  filt_cfg_t cfg,
    input  logic      raw,
    output logic      filt
);
    logic [MS_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            filt <= 1'b0;
            cnt  <= '0;
        end else if (cfg.bypass) begin
            filt <= raw;
            cnt  <= '0;
        end else if (raw == filt) begin
            cnt  <= '0;
        end else if (tick) begin
            if (cnt >= cfg.limit) begin
                filt <= raw;
                cnt  <= '0;
            end else begin
                cnt  <= cnt + MS_W'(1);
            end
        end
    end

    // Bypass: output is last cycle's raw input
    AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cfg.bypass)) |-> (filt == $past(raw))); // R5

    // Filtered changes only ever happen on a tick
    AST_CHANGE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cfg.bypass) && (filt != $past(filt))) |-> $past(tick)); // R3

    // A matching input wipes the pending count
    AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(raw == filt) |-> (cnt == '0)); // R7

endmodule

// File: rtl/debounce_bank.sv
module debounce_bank
    import dbf_pkg::*;
#(
    parameter int CHANNELS = 8,
    parameter int CLK_HZ   = 125_000_000,
    parameter int LONG_MS  = 3,
    parameter int SHORT_MS = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          dbsel,
    input  logic [CHANNELS-1:0] raw_in,
    output logic [CHANNELS-1:0] filt_out
);
    logic      ms_tick;
    filt_cfg_t cfg;

    dbf_tick_gen #(.CLK_HZ(CLK_HZ)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (ms_tick)
    );

    dbf_mode_decode #(.LONG_MS(LONG_MS), .SHORT_MS(SHORT_MS)) u_dec (
        .dbsel (dbsel),
        .cfg   (cfg)
    );

    generate
        for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
            dbf_channel u_chan (
                .clk  (clk),
                .rst  (rst),
                .tick (ms_tick),
                .cfg  (cfg),
                .raw  (raw_in[ch]),
                .filt (filt_out[ch])
            );
        end
    endgenerate

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (filt_out == '0)); // R1

    // Outside bypass, at most a tick edge may move any output
    AST_NO_OFFTICK_MOVE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cfg.bypass) && !$past(ms_tick)) |-> $stable(filt_out)); // R9

endmodule

// File: tb/debounce_bank_test.sv
`timescale 1ns/1ps
module debounce_bank_test;
    localparam int N      = 8;
    localparam int CLK_HZ = 8000;
    localparam int T      = CLK_HZ / 1000;
    localparam int LONG   = 3;
    localparam int SHORT  = 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   dbsel = 2'b11;
    logic [N-1:0] raw_in = '0;
    logic [N-1:0] filt_out;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    always #4 clk = ~clk;

    debounce_bank #(.CHANNELS(N), .CLK_HZ(CLK_HZ), .LONG_MS(LONG), .SHORT_MS(SHORT)) uut (
        .clk(clk), .rst(rst), .dbsel(dbsel), .raw_in(raw_in), .filt_out(filt_out)
    );

    // Behavioural reference: ticks seen per channel since it began to differ
    int           cyc;
    int           seen [N];
    logic [N-1:0] mdl;

    always @(posedge clk) begin
        if (rst) begin
            cyc = 0;
            mdl = '0;
            for (int i = 0; i < N; i++) seen[i] = 0;
        end else begin
            bit tk;
            int lim;
            tk  = ((cyc % T) == T - 1);
            cyc = cyc + 1;
            lim = (dbsel == 2'b10) ? SHORT : LONG;
            for (int i = 0; i < N; i++) begin
                if (dbsel == 2'b01) begin
                    mdl[i]  = raw_in[i];
                    seen[i] = 0;
                end else if (raw_in[i] == mdl[i]) begin
                    seen[i] = 0;
                end else if (tk) begin
                    if (seen[i] >= lim) begin
                        mdl[i]  = raw_in[i];
                        seen[i] = 0;
                    end else begin
                        seen[i] = seen[i] + 1;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cyc > 0 || rst) begin
            checks++;
            if (filt_out !== mdl) begin
                errors++;
                $display("FAIL %s model compare: actual %h expected %h", phase, filt_out, mdl);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_vec(input string req, input logic [N-1:0] exp);
        checks++;
        if (filt_out !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, filt_out, exp);
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        raw_in = 8'hFF;
        step(3);
        expect_vec("R1 in reset", 8'h00);
        raw_in = '0;
        rst = 1'b0;
        step(1);
        expect_vec("R1 after release", 8'h00);

        // R3 long hold, rising
        phase = "R3"; dbsel = 2'b11;
        raw_in[0] = 1'b1;
        step(LONG * T);   expect_vec("R3 still held", 8'h00);
        step(T);          expect_vec("R3 accepted", 8'h01);

        // R8 falling edge uses the same interval
        phase = "R8";
        raw_in[0] = 1'b0;
        step(LONG * T);   expect_vec("R8 fall held", 8'h01);
        step(T);          expect_vec("R8 fall accepted", 8'h00);

        // R7 interrupted change restarts
        phase = "R7";
        raw_in[1] = 1'b1; step(2 * T);
        raw_in[1] = 1'b0; step(1);
        expect_vec("R7 bounce rejected", 8'h00);
        raw_in[1] = 1'b1;
        step(LONG * T);   expect_vec("R7 restart held", 8'h00);
        step(T);          expect_vec("R7 accepted", 8'h02);

        // R6 reserved code times like long
        phase = "R6"; dbsel = 2'b00;
        raw_in[2] = 1'b1;
        step(LONG * T);   expect_vec("R6 held", 8'h02);
        step(T);          expect_vec("R6 accepted", 8'h06);

        // R4 short hold
        phase = "R4"; dbsel = 2'b10;
        raw_in[3] = 1'b1;
        step(SHORT * T);  expect_vec("R4 held", 8'h06);
        step(T);          expect_vec("R4 accepted", 8'h0E);

        // R9 one channel settles while a neighbour glitches
        phase = "R9";
        raw_in[4] = 1'b1; raw_in[5] = 1'b1;
        step(2);
        raw_in[5] = 1'b0;
        step(2 * T);      expect_vec("R9 independent", 8'h1E);

        // R5 bypass
        phase = "R5"; dbsel = 2'b01;
        raw_in = 8'hA5; step(1); expect_vec("R5 follow a", 8'hA5);
        raw_in = 8'h5A; step(1); expect_vec("R5 follow b", 8'h5A);

        // R2 tick timing is judged through the model across random traffic,
        // with mode switches and bounce landing on arbitrary prescaler phases
        phase = "R2";
        for (int k = 0; k < 3000; k++) begin
            if (($urandom % 200) == 0) dbsel = 2'($urandom);
            for (int b = 0; b < N; b++)
                if (($urandom % 23) == 0) raw_in[b] = ~raw_in[b];
            step(1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule